// File: doc/BRIEF.md
# Sampled Switch Debouncer

This block turns the chattering level of a mechanical contact into a clean logic level. The raw contact signal goes through a two-flop synchroniser first. A free-running pacer then produces one sampling strobe every `SAMPLE_INTERVAL` clock cycles. At each strobe a judge state machine compares the synchronised level with the previous sample. It counts how many strobes in a row have seen the same level. When that run reaches `AGREE_COUNT` and the agreed level differs from the present output, the output takes the new level.

At the default settings the interval is 50,000 cycles and the run length is eight. With a 50 MHz clock this gives a sample every millisecond and a nominal settling time of eight milliseconds. The block treats both directions the same way, and sampling never stops, so the output follows every level that stays steady long enough. The reset is synchronous and active high.

The judge has three named states. `JUDGE_EMPTY` holds no history and is entered at reset. `JUDGE_BUILD` holds a run shorter than `AGREE_COUNT`. `JUDGE_FULL` holds a run of full length. The transitions all happen on a strobe:
- EMPTY→BUILD on the first sample, or EMPTY→FULL when `AGREE_COUNT` is 1.
- BUILD→BUILD when a sample extends the run or restarts it.
- BUILD→FULL when the run reaches `AGREE_COUNT`.
- FULL→FULL while samples keep agreeing.
- FULL→BUILD when a sample disagrees and the run restarts at one.

Top module: `switch_debouncer`

## Requirements
- R1: While `rst` is high at a clock edge, `sw_level` is 0 after that edge. The synchroniser, the interval count and the sample history are also cleared, so the next run is counted from scratch.
- R2: A level on `sw_raw` passes through exactly two registers before the judge can sample it. At the edge k, the judge sees the value `sw_raw` had at edge k−2.
- R3: Strobes fall on the `SAMPLE_INTERVAL`-th edge after reset is released, and then on every `SAMPLE_INTERVAL` edges. `sw_level` changes on no other edge.
- R4: `sw_level` goes from 0 to 1 only at a strobe that completes a run of `AGREE_COUNT` consecutive samples that all read 1.
- R5: `sw_level` goes from 1 to 0 only at a strobe that completes a run of `AGREE_COUNT` consecutive samples that all read 0.
- R6: A sample that differs from the previous sample restarts the run at length one. Runs shorter than `AGREE_COUNT`, cut off by a differing sample, leave `sw_level` unchanged.
- R7: A sample equal to the current `sw_level` never changes `sw_level`.
- R8: Sampling never stops. After any amount of bouncing, an input held steady long enough is followed by `sw_level`, in either direction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sw_raw | input | 1 | Raw contact level, asynchronous to `clk` |
| sw_level | output | 1 | Debounced level |

## Verification
The properties assume that `rst` is held for at least one edge at start-up. They also assume that `sw_raw` is a clean binary value at every edge. The synchroniser's own metastability is not modelled, so the latency check takes the two-edge delay as exact.

The bench meets these assumptions by driving `rst` and `sw_raw` only on the falling edge, from one process, with 0 or 1 and never X. It uses a short interval and run length so that every state transition, including bounce patterns from a shift-register generator, comes up within a few hundred cycles.

// File: rtl/swdb_pkg.sv
package swdb_pkg;

    // Judge states: no history, partial run, full-length run
    typedef enum logic [1:0] {
        JUDGE_EMPTY = 2'd0,
        JUDGE_BUILD = 2'd1,
        JUDGE_FULL  = 2'd2
    } judge_state_t;

    // Bits needed to count 0 .. n-1, at least one
    function automatic int unsigned span_bits(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/swdb_sync.sv
module swdb_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= {chain_q[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/swdb_pacer.sv
module swdb_pacer
    import swdb_pkg::*;
#(
    parameter int unsigned INTERVAL = 50000
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);

    localparam int unsigned   CW   = span_bits(INTERVAL);
    localparam logic [CW-1:0] LAST = CW'(INTERVAL - 1);

    logic [CW-1:0] count_q;

    assign tick = (count_q == LAST);

    always_ff @(posedge clk) begin
        if (rst)       count_q <= '0;
        else if (tick) count_q <= '0;
        else           count_q <= count_q + CW'(1);
    end

endmodule

// File: rtl/swdb_judge.sv
module swdb_judge
    import swdb_pkg::*;
#(
    parameter int unsigned AGREE_COUNT = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic level,
    output logic decided
);

    localparam int unsigned   RW       = $clog2(AGREE_COUNT + 1);
    localparam logic [RW-1:0] FULL_RUN = RW'(AGREE_COUNT);
    localparam logic [RW-1:0] ONE_RUN  = RW'(1);

    judge_state_t  state_q, state_d;
    logic [RW-1:0] run_q, run_d;
    logic          prev_q, prev_d;
    logic          decided_q;
    logic          adopt;
    logic          same;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        run_d   = run_q;
        prev_d  = prev_q;
        same    = (level == prev_q);
        if (tick) begin
            prev_d = level;
            unique case (state_q)
                JUDGE_EMPTY: run_d = ONE_RUN;
                JUDGE_BUILD: run_d = same ? run_q + ONE_RUN : ONE_RUN;
                JUDGE_FULL:  run_d = same ? run_q : ONE_RUN;
                default:     run_d = ONE_RUN;
            endcase
            state_d = (run_d == FULL_RUN) ? JUDGE_FULL : JUDGE_BUILD;
        end
        adopt = tick && (run_d == FULL_RUN) && (level != decided_q);
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= JUDGE_EMPTY;
            run_q   <= '0;
            prev_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            run_q   <= run_d;
            prev_q  <= prev_d;
        end
    end

    // Output register
    always_ff @(posedge clk) begin
        if (rst)        decided_q <= 1'b0;
        else if (adopt) decided_q <= level;
    end

    assign decided = decided_q;

endmodule

// File: rtl/switch_debouncer.sv
module switch_debouncer #(
    parameter int unsigned SAMPLE_INTERVAL = 50000,
    parameter int unsigned AGREE_COUNT     = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic sw_raw,
    output logic sw_level
);

    localparam int unsigned SYNC_STAGES = 2;

    logic sync_lvl;
    logic sample_tick;

    swdb_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (sw_raw),
        .q   (sync_lvl)
    );

    swdb_pacer #(.INTERVAL(SAMPLE_INTERVAL)) u_pacer (
        .clk  (clk),
        .rst  (rst),
        .tick (sample_tick)
    );

    swdb_judge #(.AGREE_COUNT(AGREE_COUNT)) u_judge (
        .clk     (clk),
        .rst     (rst),
        .tick    (sample_tick),
        .level   (sync_lvl),
        .decided (sw_level)
    );

endmodule

// File: rtl/swdb_checker.sv
module swdb_checker #(
    parameter int unsigned SAMPLE_INTERVAL = 50000,
    parameter int unsigned AGREE_COUNT     = 8
) (
    input logic clk,
    input logic rst,
    input logic sw_raw,
    input logic sw_level,
    input logic sync_lvl,
    input logic sample_tick
);

    int   since_rst;
    int   gap;
    int   agree;
    logic last_smp;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_rst <= 0;
            gap       <= 0;
            agree     <= 0;
            last_smp  <= 1'b0;
        end else begin
            if (since_rst < 3) since_rst <= since_rst + 1;
            gap <= sample_tick ? 0 : gap + 1;
            if (sample_tick) begin
                last_smp <= sync_lvl;
                if (agree != 0 && sync_lvl == last_smp)
                    agree <= (agree >= int'(AGREE_COUNT)) ? agree : agree + 1;
                else
                    agree <= 1;
            end
        end
    end

    AST_RESET_LOW: assert property (@(posedge clk) rst |=> !sw_level); // R1

    AST_SYNC_DELAY: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2) |-> (sync_lvl == $past(sw_raw, 2))); // R2

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
        sample_tick |-> (gap == int'(SAMPLE_INTERVAL) - 1)); // R3

    AST_TICK_DUE: assert property (@(posedge clk) disable iff (rst)
        (gap == int'(SAMPLE_INTERVAL) - 1) |-> sample_tick); // R3

    AST_HOLD_OFF_TICK: assert property (@(posedge clk) disable iff (rst)
        !sample_tick |=> $stable(sw_level)); // R3

    AST_RISE_AFTER_RUN: assert property (@(posedge clk) disable iff (rst)
        $rose(sw_level) |-> (agree == int'(AGREE_COUNT) && last_smp)); // R4

    AST_FALL_AFTER_RUN: assert property (@(posedge clk) disable iff (rst)
        $fell(sw_level) |-> (agree == int'(AGREE_COUNT) && !last_smp)); // R5

    AST_RESTART_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (AGREE_COUNT > 1 && sample_tick && agree != 0 && sync_lvl != last_smp)
        |=> $stable(sw_level)); // R6

    AST_MATCH_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (sample_tick && sync_lvl == sw_level) |=> $stable(sw_level)); // R7

endmodule

bind switch_debouncer swdb_checker #(
    .SAMPLE_INTERVAL (SAMPLE_INTERVAL),
    .AGREE_COUNT     (AGREE_COUNT)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .sw_raw      (sw_raw),
    .sw_level    (sw_level),
    .sync_lvl    (sync_lvl),
    .sample_tick (sample_tick)
);

// File: tb/switch_debouncer_bench.sv
`timescale 1ns/1ps
module switch_debouncer_bench;

    localparam int INTERVAL = 5;
    localparam int AGREE    = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sw_raw = 1'b0;
    logic sw_level;

    int checks = 0;
    int fails  = 0;

    // Reference model state
    int   k = 0;
    logic rq[$];
    logic m_prev = 1'b0;
    int   m_run  = 0;
    logic m_out  = 1'b0;
    logic last_seen = 1'b0;
    int   changes = 0;

    always #10 clk = ~clk;

    switch_debouncer #(
        .SAMPLE_INTERVAL (INTERVAL),
        .AGREE_COUNT     (AGREE)
    ) u_switch_debouncer (
        .clk      (clk),
        .rst      (rst),
        .sw_raw   (sw_raw),
        .sw_level (sw_level)
    );

    task automatic check(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: sw_level=%0b expected %0b at edge %0d", req, act, exp, k);
        end
    endtask

    // Advance the behavioural model by the edge that just happened
    task automatic model_step(input logic v, input logic r);
        logic s;
        if (r) begin
            k = 0; rq.delete(); m_prev = 1'b0; m_run = 0; m_out = 1'b0;
        end else begin
            k++;
            s = (rq.size() >= 2) ? rq[rq.size()-2] : 1'b0;
            rq.push_back(v);
            if (rq.size() > 4) void'(rq.pop_front());
            if (k % INTERVAL == 0) begin
                if (m_run > 0 && s == m_prev) m_run = (m_run < AGREE) ? m_run + 1 : m_run;
                else                          m_run = 1;
                m_prev = s;
                if (m_run == AGREE && s != m_out) m_out = s;
            end
        end
    endtask

    task automatic cyc(input logic v, input string req);
        sw_raw = v;
        @(negedge clk);
        model_step(v, rst);
        check(sw_level, m_out, req);
        if (sw_level !== last_seen) begin
            changes++;
            if (!rst) begin
                checks++;
                if (k % INTERVAL != 0) begin
                    fails++;
                    $display("FAIL R3: sw_level changed at edge %0d, expected a multiple of %0d", k, INTERVAL);
                end
            end
        end
        last_seen = sw_level;
    endtask

    initial begin : watchdog
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : stim
        logic [7:0] lf = 8'hA5;
        int c0;
        @(negedge clk);
        // R1: reset state
        for (int i = 0; i < 3; i++) cyc(1'b1, "R1");
        check(sw_level, 1'b0, "R1");
        rst = 1'b0;
        last_seen = sw_level;
        // R2: raw high from edge 4 is first sampled at edge 10; rise at edge 25 (R4)
        for (int i = 0; i < 3; i++) cyc(1'b0, "R2");
        for (int i = 0; i < 30; i++) begin
            cyc(1'b1, "R4");
            if (k == 24) check(sw_level, 1'b0, "R2");
            if (k == 25) check(sw_level, 1'b1, "R2");
        end
        // R7: matching samples keep the level
        c0 = changes;
        for (int i = 0; i < 40; i++) cyc(1'b1, "R7");
        check(logic'(changes == c0), 1'b1, "R7");
        check(sw_level, 1'b1, "R7");
        // R6: low bursts of three samples broken by one high sample
        c0 = changes;
        for (int r = 0; r < 3; r++) begin
            for (int i = 0; i < 15; i++) cyc(1'b0, "R6");
            for (int i = 0; i < 5; i++)  cyc(1'b1, "R6");
        end
        check(logic'(changes == c0), 1'b1, "R6");
        check(sw_level, 1'b1, "R6");
        // R5: steady low falls after a full run
        for (int i = 0; i < 30; i++) cyc(1'b0, "R5");
        check(sw_level, 1'b0, "R5");
        // R8: bounce, then settle high, then bounce, settle low
        for (int i = 0; i < 60; i++) begin
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            cyc(lf[0], "R8");
        end
        for (int i = 0; i < 30; i++) cyc(1'b1, "R8");
        check(sw_level, 1'b1, "R8");
        for (int i = 0; i < 60; i++) begin
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            cyc(lf[1], "R8");
        end
        for (int i = 0; i < 30; i++) cyc(1'b0, "R8");
        check(sw_level, 1'b0, "R8");
        // R1: reset in mid-operation while high
        for (int i = 0; i < 30; i++) cyc(1'b1, "R4");
        check(sw_level, 1'b1, "R4");
        rst = 1'b1;
        for (int i = 0; i < 2; i++) cyc(1'b1, "R1");
        check(sw_level, 1'b0, "R1");
        rst = 1'b0;
        last_seen = sw_level;
        for (int i = 0; i < 30; i++) begin
            cyc(1'b1, "R1");
            if (k == 19) check(sw_level, 1'b0, "R1");
            if (k == 20) check(sw_level, 1'b1, "R1");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule